// File: doc/BRIEF.md
# Character LCD bus interface controller

This block is a bus master for a parallel character-LCD port. The port has an enable strobe, a register-select line, a read/write line and an 8-bit data bus. The bus is split into a driven byte, an output-enable and a sampled byte, so that the pad ring can build the bidirectional pins. Software programs the strobe timing and the bus mode through a small register interface. It then issues single read or write commands by setting a command bit, and that bit clears itself when the command has finished.

Each command performs one 8-bit transfer, or two 4-bit transfers with the high nibble first. Every transfer runs four phases in a fixed order: setup, enable active, hold, then enable inactive. Each phase length is counted in system clocks from a programmable field. A DMA request output tells a DMA engine when the controller can take another write word.

Top module: `lcd_port_ctrl`

## Requirements
- R1: Register map. Address 0 is the configuration word: active time in bits 31:24, gap in 23:16, setup in 15:12, hold in 11:8, DMA enable in bit 2, 8-bit width in bit 1 and polarity in bit 0. Address 1 is the write register and address 2 is the read register; bit 15 of each is its command bit. After reset the configuration reads 0xFFFFFF00, both command bits read 0, the strobe is high (inactive) and dma_req is low.
- R2: With a setup field of n, the strobe first goes active n+1 cycles after the clock edge that accepts a command. The second nibble's pulse likewise starts n+1 cycles after that nibble begins.
- R3: With an active field of n, each strobe pulse lasts 2*(n+1) consecutive cycles.
- R4: A hold of (hold field + 1) cycles and a gap of 32*(gap field + 1) cycles follow each pulse, which gives a transfer period T. The command bit reads 0 exactly N*T cycles after the accepting edge, with N = 1 in 8-bit mode and N = 2 in 4-bit mode.
- R5: When the polarity bit is 1 the strobe is active high; when it is 0 the strobe is active low. While no command runs, the strobe sits at its inactive level.
- R6: A write in 8-bit mode (bit 1 = 1) makes exactly one pulse. During it lcd_d_out carries bits 7:0 of the write register, lcd_d_oe is 1, lcd_rw is 0 and lcd_rs equals bit 8. These lines stay stable for every active cycle.
- R7: A write in 4-bit mode (bit 1 = 0) makes two pulses. The first carries bits 7:4 and the second bits 3:0, both on lcd_d_out[7:4], while lcd_d_out[3:0] is 0.
- R8: A read command (address 2, bit 15 = 1) holds lcd_d_oe at 0 and lcd_rw at 1, and drives lcd_rs from bit 8. It samples lcd_d_in in the last active cycle of each pulse. In 8-bit mode it takes the whole byte. In 4-bit mode it takes lcd_d_in[7:4] twice, as the high nibble and then the low nibble. The result reads back in bits 7:0 of address 2.
- R9: While either command bit is 1, writes to addresses 1 and 2 are ignored: they change no stored data or register-select bit and start no command.
- R10: dma_req is 1 exactly when the DMA enable bit is 1 and the write command bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase lengths count it |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 write, 2 read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the addressed register (combinational) |
| dma_req | output | 1 | Request for a 16-bit word into the write register |
| lcd_en | output | 1 | Enable strobe toward the display |
| lcd_rs | output | 1 | Register-select line |
| lcd_rw | output | 1 | 1 for read, 0 for write |
| lcd_d_out | output | 8 | Data driven toward the display |
| lcd_d_oe | output | 1 | Output enable for the data pads |
| lcd_d_in | input | 8 | Data sampled from the display pads |

## Verification
A command is accepted at a clock edge, and the bench counts sampling points from the first falling edge after that edge as cycle 0. The first pulse is due at cycle setup+1 and lasts 2*(active+1) cycles. A second nibble starts at cycle T, and the command bit must read 0 at exactly N*T. Configuration, DMA request and readback values are due one cycle after the register write, because readback and dma_req decode registered state combinationally. Every sample is taken 1 ns after a falling edge, and the expected values come from bench functions of the random configuration. Random writes are also injected into the command registers at cycle 2 of a command, and the bench checks that they leave no trace on the pins or in the readback.

// File: rtl/lcd_port_pkg.sv
`timescale 1ns/1ps
package lcd_port_pkg;
    localparam int DATA_W    = 8;
    localparam int NIB_W     = DATA_W / 2;
    localparam int ACT_W     = 8;
    localparam int GAP_W     = 8;
    localparam int SU_W      = 4;
    localparam int HOLD_W    = 4;
    localparam int GAP_SHIFT = 5;
    localparam int CNT_W     = GAP_W + GAP_SHIFT;
    localparam int REG_W     = 32;
    localparam int CMD_BIT   = 15;
    localparam int RS_BIT    = 8;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_WR  = 2'd1;
    localparam logic [1:0] ADDR_RD  = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_GAP
    } phase_e;

    typedef struct packed {
        logic [ACT_W-1:0]  act;
        logic [GAP_W-1:0]  gap;
        logic [SU_W-1:0]   su;
        logic [HOLD_W-1:0] hold;
        logic              dma_en;
        logic              wide;
        logic              pol;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic              wr_go;
        logic              wr_rs;
        logic [DATA_W-1:0] wr_data;
        logic              rd_go;
        logic              rd_rs;
        logic [DATA_W-1:0] rd_data;
    } regs_t;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              nib;
        logic              rd;
        logic              rs;
        logic              wide;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] cap;
    } seq_t;
endpackage

// File: rtl/lcd_phase_len.sv
`timescale 1ns/1ps
module lcd_phase_len
    import lcd_port_pkg::*;
(
    input  phase_e           ph,
    input  cfg_t             cfg,
    output logic [CNT_W-1:0] len_m1
);
    // Each field encodes (length - 1) after scaling; the scale is a shift, so
    // the low bits are all ones.
    always_comb begin
        case (ph)
            PH_SETUP:  len_m1 = CNT_W'(cfg.su);
            PH_ACTIVE: len_m1 = CNT_W'({cfg.act, 1'b1});
            PH_HOLD:   len_m1 = CNT_W'(cfg.hold);
            PH_GAP:    len_m1 = CNT_W'({cfg.gap, {GAP_SHIFT{1'b1}}});
            default:   len_m1 = '0;
        endcase
    end
endmodule

// File: rtl/lcd_port_regs.sv
`timescale 1ns/1ps
module lcd_port_regs
    import lcd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] cap,
    output cfg_t              cfg,
    output logic              busy,
    output logic              wr_pend,
    output logic              start,
    output logic              start_rd,
    output logic              start_rs,
    output logic [DATA_W-1:0] start_data,
    output logic [RS_BIT:0]   wr_word
);
    regs_t q, d;
    logic  cmd_addr;

    assign busy       = q.wr_go | q.rd_go;
    assign wr_pend    = q.wr_go;
    assign cfg        = q.cfg;
    assign cmd_addr   = (reg_addr == ADDR_WR) || (reg_addr == ADDR_RD);
    assign start      = reg_we && !busy && cmd_addr && reg_wdata[CMD_BIT];
    assign start_rd   = (reg_addr == ADDR_RD);
    assign start_rs   = reg_wdata[RS_BIT];
    assign start_data = reg_wdata[DATA_W-1:0];
    assign wr_word    = {q.wr_rs, q.wr_data};

    always_comb begin
        d = q;
        if (done) begin
            if (q.rd_go) d.rd_data = cap;
            d.wr_go = 1'b0;
            d.rd_go = 1'b0;
        end
        if (reg_we) begin
            case (reg_addr)
                ADDR_CFG: begin
                    d.cfg.act    = reg_wdata[31:24];
                    d.cfg.gap    = reg_wdata[23:16];
                    d.cfg.su     = reg_wdata[15:12];
                    d.cfg.hold   = reg_wdata[11:8];
                    d.cfg.dma_en = reg_wdata[2];
                    d.cfg.wide   = reg_wdata[1];
                    d.cfg.pol    = reg_wdata[0];
                end
                ADDR_WR: if (!busy) begin
                    d.wr_go   = reg_wdata[CMD_BIT];
                    d.wr_rs   = reg_wdata[RS_BIT];
                    d.wr_data = reg_wdata[DATA_W-1:0];
                end
                ADDR_RD: if (!busy) begin
                    d.rd_go = reg_wdata[CMD_BIT];
                    d.rd_rs = reg_wdata[RS_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CFG: reg_rdata = {q.cfg.act, q.cfg.gap, q.cfg.su, q.cfg.hold,
                                   5'b0, q.cfg.dma_en, q.cfg.wide, q.cfg.pol};
            ADDR_WR:  reg_rdata = {16'b0, q.wr_go, 6'b0, q.wr_rs, q.wr_data};
            ADDR_RD:  reg_rdata = {16'b0, q.rd_go, 6'b0, q.rd_rs, q.rd_data};
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cfg.act  <= '1;
            q.cfg.gap  <= '1;
            q.cfg.su   <= '1;
            q.cfg.hold <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lcd_xfer_seq.sv
`timescale 1ns/1ps
module lcd_xfer_seq
    import lcd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              start,
    input  logic              start_rd,
    input  logic              start_rs,
    input  logic [DATA_W-1:0] start_data,
    input  logic [DATA_W-1:0] lcd_d_in,
    output logic              done,
    output logic [DATA_W-1:0] cap,
    output logic              lcd_en,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_d_oe,
    output logic [DATA_W-1:0] lcd_d_out
);
    seq_t             q, d;
    phase_e           tgt;
    logic [CNT_W-1:0] tgt_len;
    logic             last_cyc;
    logic             last_xfer;
    logic             active;
    logic             running;
    logic [NIB_W-1:0] nib_sel;

    always_comb begin
        case (q.phase)
            PH_SETUP:  tgt = PH_ACTIVE;
            PH_ACTIVE: tgt = PH_HOLD;
            PH_HOLD:   tgt = PH_GAP;
            default:   tgt = PH_SETUP;
        endcase
    end

    lcd_phase_len u_len (
        .ph     (tgt),
        .cfg    (cfg),
        .len_m1 (tgt_len)
    );

    assign last_cyc  = (q.cnt == '0);
    assign last_xfer = q.wide | q.nib;
    assign running   = (q.phase != PH_IDLE);
    assign active    = (q.phase == PH_ACTIVE);

    always_comb begin
        d    = q;
        done = 1'b0;
        if (q.phase == PH_IDLE) begin
            if (start) begin
                d.phase = PH_SETUP;
                d.cnt   = tgt_len;
                d.nib   = 1'b0;
                d.rd    = start_rd;
                d.rs    = start_rs;
                d.wide  = cfg.wide;
                d.data  = start_data;
                d.cap   = '0;
            end
        end else if (!last_cyc) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            d.cnt = tgt_len;
            case (q.phase)
                PH_SETUP: d.phase = PH_ACTIVE;
                PH_ACTIVE: begin
                    d.phase = PH_HOLD;
                    if (q.rd) begin
                        if (q.wide)      d.cap = lcd_d_in;
                        else if (!q.nib) d.cap[DATA_W-1:NIB_W] = lcd_d_in[DATA_W-1:NIB_W];
                        else             d.cap[NIB_W-1:0] = lcd_d_in[DATA_W-1:NIB_W];
                    end
                end
                PH_HOLD: d.phase = PH_GAP;
                default: begin
                    if (last_xfer) begin
                        d.phase = PH_IDLE;
                        done    = 1'b1;
                    end else begin
                        d.phase = PH_SETUP;
                        d.nib   = 1'b1;
                    end
                end
            endcase
        end
    end

    assign nib_sel   = q.nib ? q.data[NIB_W-1:0] : q.data[DATA_W-1:NIB_W];
    assign cap       = q.cap;
    assign lcd_en    = active ? cfg.pol : ~cfg.pol;
    assign lcd_rs    = running & q.rs;
    assign lcd_rw    = running & q.rd;
    assign lcd_d_oe  = running & ~q.rd;

    always_comb begin
        if (!running || q.rd) lcd_d_out = '0;
        else if (q.wide)      lcd_d_out = q.data;
        else                  lcd_d_out = {nib_sel, {NIB_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lcd_port_ctrl.sv
`timescale 1ns/1ps
module lcd_port_ctrl
    import lcd_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        dma_req,
    output logic        lcd_en,
    output logic        lcd_rs,
    output logic        lcd_rw,
    output logic [7:0]  lcd_d_out,
    output logic        lcd_d_oe,
    input  logic [7:0]  lcd_d_in
);
    cfg_t              cfg;
    logic              busy;
    logic              wr_pend;
    logic              start;
    logic              start_rd;
    logic              start_rs;
    logic [DATA_W-1:0] start_data;
    logic              done;
    logic [DATA_W-1:0] cap;
    logic [RS_BIT:0]   wr_word;
    logic              cfg_pol;
    logic              cfg_wide;

    lcd_port_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .done       (done),
        .cap        (cap),
        .cfg        (cfg),
        .busy       (busy),
        .wr_pend    (wr_pend),
        .start      (start),
        .start_rd   (start_rd),
        .start_rs   (start_rs),
        .start_data (start_data),
        .wr_word    (wr_word)
    );

    lcd_xfer_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .start      (start),
        .start_rd   (start_rd),
        .start_rs   (start_rs),
        .start_data (start_data),
        .lcd_d_in   (lcd_d_in),
        .done       (done),
        .cap        (cap),
        .lcd_en     (lcd_en),
        .lcd_rs     (lcd_rs),
        .lcd_rw     (lcd_rw),
        .lcd_d_oe   (lcd_d_oe),
        .lcd_d_out  (lcd_d_out)
    );

    assign cfg_pol  = cfg.pol;
    assign cfg_wide = cfg.wide;
    assign dma_req  = cfg.dma_en & ~wr_pend;
endmodule

// File: rtl/lcd_port_chk.sv
`timescale 1ns/1ps
module lcd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wr_pend,
    input logic       cfg_pol,
    input logic       cfg_wide,
    input logic       dma_req,
    input logic       reg_we,
    input logic       lcd_en,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_d_oe,
    input logic [7:0] lcd_d_out,
    input logic [8:0] wr_word
);
    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_en == !cfg_pol));

    p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |-> !dma_req);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> $stable(wr_word));

    p_read_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_pend) |-> (!lcd_d_oe && lcd_rw));

    p_low_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_d_oe && !cfg_wide) |-> (lcd_d_out[3:0] == 4'h0));

    p_pulse_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en == cfg_pol) |-> ($stable(lcd_d_out) && $stable(lcd_rs) && $stable(lcd_rw)));
endmodule

bind lcd_port_ctrl lcd_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_pend   (wr_pend),
    .cfg_pol   (cfg_pol),
    .cfg_wide  (cfg_wide),
    .dma_req   (dma_req),
    .reg_we    (reg_we),
    .lcd_en    (lcd_en),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_d_oe  (lcd_d_oe),
    .lcd_d_out (lcd_d_out),
    .wr_word   (wr_word)
);

// File: tb/sim_lcd_port_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dma_req;
    logic        lcd_en;
    logic        lcd_rs;
    logic        lcd_rw;
    logic [7:0]  lcd_d_out;
    logic        lcd_d_oe;
    logic [7:0]  lcd_d_in;

    int n_chk  = 0;
    int n_fail = 0;

    int ca, cg, cs, ch;
    bit cdma, cwide, cpol;
    logic [8:0] exp_wr;

    always #2.5 clk = ~clk;

    lcd_port_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_req   (dma_req),
        .lcd_en    (lcd_en),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_d_out (lcd_d_out),
        .lcd_d_oe  (lcd_d_oe),
        .lcd_d_in  (lcd_d_in)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int period_len();
        return (cs + 1) + 2 * (ca + 1) + (ch + 1) + 32 * (cg + 1);
    endfunction

    function automatic logic [7:0] exp_bus(input logic [7:0] v, input int p);
        if (cwide) return v;
        return (p == 0) ? {v[7:4], 4'h0} : {v[3:0], 4'h0};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic set_cfg(input int a, input int g, input int s, input int h,
                           input bit dm, input bit w, input bit p);
        ca = a; cg = g; cs = s; ch = h; cdma = dm; cwide = w; cpol = p;
        reg_write(2'd0, {8'(a), 8'(g), 4'(s), 4'(h), 5'b0, dm, w, p});
        #1;
        chk(lcd_en == !cpol, "R5 idle level", lcd_en, !cpol);
        chk(dma_req == cdma, "R10 idle request", dma_req, cdma);
    endtask

    task automatic run_cmd(input bit is_rd, input bit rs, input logic [7:0] data, input bit inject);
        int T, npx, idx, clr, np;
        int pst[2], plen[2];
        logic [7:0] pd[2];
        bit poe[2], prw[2], prs[2];
        bit prev, act, dma_bad, inj_on;
        logic [7:0] rb;
        logic [1:0] a;
        T   = period_len();
        npx = cwide ? 1 : 2;
        rb  = 8'($urandom);
        a   = is_rd ? 2'd2 : 2'd1;
        for (int p = 0; p < 2; p++) begin
            pst[p] = -1; plen[p] = -1; pd[p] = '0; poe[p] = 0; prw[p] = 0; prs[p] = 0;
        end
        reg_write(a, {16'h0, 1'b1, 6'b0, rs, data});
        if (!is_rd) exp_wr = {rs, data};
        reg_addr = a;
        idx = 0; np = 0; prev = 0; clr = -1; dma_bad = 0; inj_on = 0;
        while (1) begin
            if (inj_on) begin
                reg_we   = 1'b0;
                reg_addr = a;
                inj_on   = 0;
            end
            #1;
            act = (lcd_en == cpol);
            if (act && !prev) begin
                if (np < 2) begin
                    pst[np] = idx; pd[np] = lcd_d_out;
                    poe[np] = lcd_d_oe; prw[np] = lcd_rw; prs[np] = lcd_rs;
                end
                if (is_rd)
                    lcd_d_in = (np == 0) ? (cwide ? rb : {rb[7:4], 4'($urandom)})
                                         : {rb[3:0], 4'($urandom)};
                np++;
            end
            if (!act && prev && np >= 1 && np <= 2) plen[np-1] = idx - pst[np-1];
            prev = act;
            if (reg_rdata[15] == 1'b0) begin
                clr = idx;
                break;
            end
            if (!is_rd && dma_req) dma_bad = 1;
            if (idx > 40000) break;
            if (inject && idx == 2) begin
                reg_we    = 1'b1;
                reg_addr  = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
                reg_wdata = {16'h0, 1'b1, 6'b0, ~rs, ~data};
                inj_on    = 1;
            end
            @(negedge clk);
            idx++;
        end
        chk(clr == npx * T, "R4 command length", clr, npx * T);
        chk(np == npx, cwide ? "R6 pulse count" : "R7 pulse count", np, npx);
        for (int p = 0; p < npx; p++) begin
            chk(pst[p] == p * T + cs + 1, "R2 setup", pst[p], p * T + cs + 1);
            chk(plen[p] == 2 * (ca + 1), "R3 active", plen[p], 2 * (ca + 1));
            if (!is_rd) begin
                chk(pd[p] == exp_bus(data, p), cwide ? "R6 data" : "R7 nibble",
                    pd[p], exp_bus(data, p));
                chk(poe[p] && !prw[p] && prs[p] == rs, "R6 control",
                    {poe[p], prw[p], prs[p]}, {1'b1, 1'b0, rs});
            end else begin
                chk(!poe[p] && prw[p] && prs[p] == rs, "R8 control",
                    {poe[p], prw[p], prs[p]}, {1'b0, 1'b1, rs});
            end
        end
        @(negedge clk);
        reg_addr = 2'd2;
        #1;
        if (is_rd) chk(reg_rdata[7:0] == rb, "R8 captured byte", reg_rdata[7:0], rb);
        chk(reg_rdata[15] == 1'b0, "R9 no read started", reg_rdata[15], 0);
        reg_addr = 2'd1;
        #1;
        chk(reg_rdata[15:0] == {7'b0, exp_wr}, "R9 write register kept",
            reg_rdata[15:0], {7'b0, exp_wr});
        if (!is_rd) chk(!dma_bad, "R10 request while pending", dma_bad, 0);
        chk(dma_req == cdma, "R10 request after", dma_req, cdma);
        chk(lcd_en == !cpol, "R5 idle after command", lcd_en, !cpol);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; lcd_d_in = '0;
        exp_wr = '0;
        ca = 255; cg = 255; cs = 15; ch = 15; cdma = 0; cwide = 0; cpol = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(reg_rdata == 32'hFFFF_FF00, "R1 config reset", reg_rdata, 32'hFFFF_FF00);
        chk(lcd_en == 1'b1, "R1 strobe reset", lcd_en, 1);
        chk(dma_req == 1'b0, "R1 request reset", dma_req, 0);
        reg_addr = 2'd1;
        #1;
        chk(reg_rdata[15] == 1'b0, "R1 write command reset", reg_rdata[15], 0);
        reg_addr = 2'd2;
        #1;
        chk(reg_rdata[15] == 1'b0, "R1 read command reset", reg_rdata[15], 0);

        // longest timing, 4-bit, active-low strobe
        run_cmd(0, 1, 8'hA5, 1);

        // shortest timing in both widths and polarities
        set_cfg(0, 0, 0, 0, 1, 1, 1);
        run_cmd(0, 0, 8'h3C, 0);
        run_cmd(1, 1, 8'h00, 1);
        set_cfg(0, 0, 0, 0, 1, 0, 0);
        run_cmd(0, 1, 8'hF0, 0);
        run_cmd(1, 0, 8'h00, 0);

        for (int i = 0; i < 40; i++) begin
            set_cfg($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 4,
                    1'($urandom), 1'($urandom), 1'($urandom));
            for (int j = 0; j < 2; j++)
                run_cmd(1'($urandom), 1'($urandom), 8'($urandom), ($urandom % 3) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule